// File: doc/BRIEF.md
# Exception Escalation Controller

This block sits in front of a processor's interrupt entry logic and decides what happens when a fault is raised. It keeps a small nesting level: every raise increases it, and only a successful entry into the handler, reported back by the entry logic, returns it to zero. A first raise is passed on with its own vector. A raise that arrives while an earlier one has not yet been delivered is turned into a double fault. A third raise in a row resets the processor instead of delivering anything.

Each accepted raise gives one registered decision, one cycle after the strobe. That decision is one of two things. Either it is a delivery, which carries the vector, the error-code push flag and the error code, together with one-cycle pulses that rewind the instruction pointer and drop the prefix state. Or it is a processor reset pulse. The entry logic pushes the frame and reports the outcome through `deliver_ok_i`.

Top module: `fault_escalator`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is 0. Reset also returns the nesting level to zero, so the first raise after reset delivers its own vector.
- R2: When the nesting level is zero, a raise in cycle t gives `dlv_valid_o`=1 with `dlv_vec_o` equal to the raised vector in cycle t+1. `ip_restore_o` and `prefix_clr_o` are also 1 in that cycle.
- R3: A raise that arrives while the level is 1 (an earlier raise with no success since) is delivered with the double-fault vector 8 in place of its own.
- R4: A raise that brings the level to 3 gives `cpu_reset_o`=1 for one cycle. In that cycle `dlv_valid_o`, `ip_restore_o` and `prefix_clr_o` are 0. The level returns to zero, so the following raise delivers its own vector.
- R5: `dlv_push_err_o` is 1 exactly when a delivery carries a vector in {8, 10, 11, 12, 13, 14, 17} and `prot_en_i` was 1 in the raise cycle.
- R6: `dlv_err_o` equals the raise's error code when `dlv_push_err_o` is 1, and is 0 otherwise.
- R7: A `deliver_ok_i` pulse returns the level to zero, so the next raise delivers its own vector.
- R8: When `deliver_ok_i` and a raise share a cycle, the success is applied first, and the raise is delivered with its own vector.
- R9: The outputs are pulses. In a cycle after one with no raise, `dlv_valid_o`, `cpu_reset_o`, `ip_restore_o` and `prefix_clr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | 1 | Exception raise strobe |
| raise_vec_i | input | 8 | Vector being raised |
| raise_err_i | input | 32 | Error code of the raise |
| deliver_ok_i | input | 1 | Handler entry completed successfully |
| prot_en_i | input | 1 | Protected mode enabled |
| dlv_valid_o | output | 1 | A vector is to be delivered |
| dlv_vec_o | output | 8 | Vector to deliver |
| dlv_push_err_o | output | 1 | Push the error code onto the handler frame |
| dlv_err_o | output | 32 | Error code to push |
| ip_restore_o | output | 1 | Rewind the instruction pointer to the start of the instruction |
| prefix_clr_o | output | 1 | Drop the accumulated prefix state |
| cpu_reset_o | output | 1 | Triple fault: reset the processor |

## Verification
The hardest state to reach is the third nested raise, because the level only climbs when no success is reported between raises. The bench reaches it by issuing back-to-back raises with `deliver_ok_i` held low. It also drives a success in the same cycle as a raise, to check the order in which the two are applied. A reset in the middle of a nest checks that the hidden level does not survive reset.

// File: rtl/fesc_pkg.sv
package fesc_pkg;

  localparam int VEC_W = 8;

  typedef struct packed {
    logic             valid;
    logic [VEC_W-1:0] vec;
    logic             push;
    logic             fatal;
  } fesc_decision_t;

  // Vectors whose handler frame carries an error code.
  function automatic logic has_errcode(input logic [VEC_W-1:0] v);
    case (v)
      8'd8, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd17: has_errcode = 1'b1;
      default:                                         has_errcode = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fesc_depth.sv
module fesc_depth #(
  parameter int DEPTH_W     = 2,
  parameter int FATAL_LEVEL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raise_i,
  input  logic               ok_i,
  output logic [DEPTH_W-1:0] level_o,
  output logic               fatal_o
);
  localparam logic [DEPTH_W-1:0] FATAL = DEPTH_W'(FATAL_LEVEL);
  localparam logic [DEPTH_W-1:0] TOP   = {DEPTH_W{1'b1}};

  logic [DEPTH_W-1:0] depth_q, depth_d, base;

  function automatic logic [DEPTH_W-1:0] sat_inc(input logic [DEPTH_W-1:0] x);
    sat_inc = (x == TOP) ? x : x + 1'b1;
  endfunction

  // A success is applied before a raise in the same cycle.
  assign base    = ok_i ? '0 : depth_q;
  assign level_o = sat_inc(base);
  assign fatal_o = raise_i && (level_o == FATAL);

  always_comb begin
    if (!raise_i)     depth_d = base;
    else if (fatal_o) depth_d = '0;
    else              depth_d = level_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) depth_q <= '0;
    else        depth_q <= depth_d;
  end

  AST_DEPTH_BELOW_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q < FATAL); // R4
  AST_OK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_i && !raise_i) |=> (depth_q == '0)); // R7

endmodule

// File: rtl/fesc_select.sv
module fesc_select
  import fesc_pkg::*;
#(
  parameter int DEPTH_W = 2,
  parameter int DF_VEC  = 8
) (
  input  logic               raise_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [DEPTH_W-1:0] level_i,
  input  logic               fatal_i,
  input  logic               prot_i,
  output fesc_decision_t     dec_o
);
  localparam logic [VEC_W-1:0] DF = VEC_W'(DF_VEC);

  logic [VEC_W-1:0] vec_sel;
  logic             nested;

  assign nested  = level_i > DEPTH_W'(1);
  assign vec_sel = nested ? DF : vec_i;

  always_comb begin
    dec_o.valid = raise_i && !fatal_i;
    dec_o.fatal = fatal_i;
    dec_o.vec   = dec_o.valid ? vec_sel : '0;
    dec_o.push  = dec_o.valid && prot_i && has_errcode(vec_sel);
  end

  always_comb begin
    assert (!(dec_o.valid && dec_o.fatal)); // R4
  end

endmodule

// File: rtl/fesc_outreg.sv
module fesc_outreg
  import fesc_pkg::*;
#(
  parameter int ERR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fesc_decision_t    dec_i,
  input  logic [ERR_W-1:0]  err_i,
  output logic              valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              push_o,
  output logic [ERR_W-1:0]  err_o,
  output logic              ip_restore_o,
  output logic              prefix_clr_o,
  output logic              reset_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o      <= 1'b0;
      vec_o        <= '0;
      push_o       <= 1'b0;
      err_o        <= '0;
      ip_restore_o <= 1'b0;
      prefix_clr_o <= 1'b0;
      reset_o      <= 1'b0;
    end else begin
      valid_o      <= dec_i.valid;
      vec_o        <= dec_i.vec;
      push_o       <= dec_i.push;
      err_o        <= dec_i.push ? err_i : '0;
      ip_restore_o <= dec_i.valid;
      prefix_clr_o <= dec_i.valid;
      reset_o      <= dec_i.fatal;
    end
  end

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !push_o |-> (err_o == '0)); // R6
  AST_RESET_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_o |-> !(valid_o || ip_restore_o || prefix_clr_o)); // R4

endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
  import fesc_pkg::*;
#(
  parameter int ERR_W       = 32,
  parameter int DEPTH_W     = 2,
  parameter int FATAL_LEVEL = 3,
  parameter int DF_VEC      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_i,
  input  logic [VEC_W-1:0]  raise_vec_i,
  input  logic [ERR_W-1:0]  raise_err_i,
  input  logic              deliver_ok_i,
  input  logic              prot_en_i,
  output logic              dlv_valid_o,
  output logic [VEC_W-1:0]  dlv_vec_o,
  output logic              dlv_push_err_o,
  output logic [ERR_W-1:0]  dlv_err_o,
  output logic              ip_restore_o,
  output logic              prefix_clr_o,
  output logic              cpu_reset_o
);
  logic [DEPTH_W-1:0] level;
  logic               fatal;
  fesc_decision_t     dec;

  fesc_depth #(.DEPTH_W(DEPTH_W), .FATAL_LEVEL(FATAL_LEVEL)) u_depth (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .ok_i(deliver_ok_i),
    .level_o(level), .fatal_o(fatal));

  fesc_select #(.DEPTH_W(DEPTH_W), .DF_VEC(DF_VEC)) u_sel (
    .raise_i(raise_i), .vec_i(raise_vec_i), .level_i(level),
    .fatal_i(fatal), .prot_i(prot_en_i), .dec_o(dec));

  fesc_outreg #(.ERR_W(ERR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .dec_i(dec), .err_i(raise_err_i),
    .valid_o(dlv_valid_o), .vec_o(dlv_vec_o), .push_o(dlv_push_err_o),
    .err_o(dlv_err_o), .ip_restore_o(ip_restore_o),
    .prefix_clr_o(prefix_clr_o), .reset_o(cpu_reset_o));

  AST_PULSE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid_o |-> (ip_restore_o && prefix_clr_o)); // R2
  AST_NESTED_DF: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i && !fatal && level > DEPTH_W'(1)) |=> (dlv_vec_o == VEC_W'(DF_VEC))); // R3
  AST_PUSH_NEEDS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_push_err_o |-> $past(prot_en_i)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(raise_i) |-> !(dlv_valid_o || cpu_reset_o)); // R9
  AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset_o |=> !cpu_reset_o); // R4

endmodule

// File: tb/sim_fault_escalator.sv
module sim_fault_escalator;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS      = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raise = 1'b0;
  logic [7:0]  vec = '0;
  logic [31:0] err = '0;
  logic        ok = 1'b0;
  logic        prot = 1'b0;
  logic        dv, dpush, iprs, pclr, creset;
  logic [7:0]  dvec;
  logic [31:0] derr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_escalator u0 (
    .clk(clk), .rst_n(rst_n), .raise_i(raise), .raise_vec_i(vec),
    .raise_err_i(err), .deliver_ok_i(ok), .prot_en_i(prot),
    .dlv_valid_o(dv), .dlv_vec_o(dvec), .dlv_push_err_o(dpush),
    .dlv_err_o(derr), .ip_restore_o(iprs), .prefix_clr_o(pclr),
    .cpu_reset_o(creset));

  // {raise, vec, ok, prot, exp_valid, exp_vec, exp_push, exp_reset}
  localparam logic [21:0] TBL [NROWS] = '{
    {1'b1, 8'h0D, 1'b0, 1'b1,  1'b1, 8'h0D, 1'b1, 1'b0},  // R2 R5 level 1
    {1'b0, 8'h00, 1'b1, 1'b1,  1'b0, 8'h00, 1'b0, 1'b0},  // R7 success
    {1'b1, 8'h03, 1'b0, 1'b1,  1'b1, 8'h03, 1'b0, 1'b0},  // R7 own vector
    {1'b1, 8'h0E, 1'b0, 1'b1,  1'b1, 8'h08, 1'b1, 1'b0},  // R3 double fault
    {1'b1, 8'h20, 1'b0, 1'b1,  1'b0, 8'h00, 1'b0, 1'b1},  // R4 triple
    {1'b1, 8'h11, 1'b0, 1'b0,  1'b1, 8'h11, 1'b0, 1'b0},  // R4 cleared, R5 prot off
    {1'b1, 8'h06, 1'b1, 1'b0,  1'b1, 8'h06, 1'b0, 1'b0},  // R8 ok with raise
    {1'b1, 8'h0A, 1'b0, 1'b0,  1'b1, 8'h08, 1'b0, 1'b0},  // R3 R5 DF no prot
    {1'b0, 8'h00, 1'b1, 1'b1,  1'b0, 8'h00, 1'b0, 1'b0},  // R7
    {1'b1, 8'h0B, 1'b0, 1'b1,  1'b1, 8'h0B, 1'b1, 1'b0},  // R5
    {1'b0, 8'h00, 1'b0, 1'b1,  1'b0, 8'h00, 1'b0, 1'b0},  // R9 idle
    {1'b1, 8'h09, 1'b0, 1'b1,  1'b1, 8'h08, 1'b1, 1'b0},  // R3
    {1'b1, 8'h01, 1'b0, 1'b1,  1'b0, 8'h00, 1'b0, 1'b1},  // R4
    {1'b1, 8'h0C, 1'b0, 1'b1,  1'b1, 8'h0C, 1'b1, 1'b0},  // R4 R9 single pulse
    {1'b0, 8'h00, 1'b1, 1'b1,  1'b0, 8'h00, 1'b0, 1'b0},  // R7
    {1'b1, 8'h12, 1'b0, 1'b1,  1'b1, 8'h12, 1'b0, 1'b0},  // R5 18 not in class
    {1'b0, 8'h00, 1'b1, 1'b1,  1'b0, 8'h00, 1'b0, 1'b0}   // R9
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input logic ev, input logic [7:0] evec,
                            input logic ep, input logic [31:0] eerr,
                            input logic er);
    check("R2", "valid", 64'(dv), 64'(ev));
    check("R3", "vector", 64'(dvec), 64'(evec));
    check("R5", "push", 64'(dpush), 64'(ep));
    check("R6", "errcode", 64'(derr), 64'(eerr));
    check("R4", "cpu_reset", 64'(creset), 64'(er));
    check("R9", "restore/prefix", 64'({iprs, pclr}), 64'({ev, ev}));
  endtask

  task automatic drive(input logic r, input logic [7:0] v, input logic o,
                       input logic p, input logic [31:0] e);
    raise = r; vec = v; ok = o; prot = p; err = e;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    expect_out(1'b0, 8'h00, 1'b0, 32'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(1'b0, 8'h00, 1'b0, 32'h0, 1'b0); // R1

    for (int i = 0; i < NROWS; i++) begin
      logic r, o, p, ev, ep, er;
      logic [7:0] v, evec;
      logic [31:0] e;
      {r, v, o, p, ev, evec, ep, er} = TBL[i];
      e = 32'hC0DE_0000 + 32'(i);
      drive(r, v, o, p, e);
      @(negedge clk);
      expect_out(ev, evec, ep, ep ? e : 32'h0, er);
    end
    drive(1'b0, 8'h00, 1'b0, 1'b0, 32'h0);
    @(negedge clk);

    // R1: reset in the middle of a nest discards the level
    drive(1'b1, 8'h05, 1'b0, 1'b1, 32'h1111);
    @(negedge clk);
    expect_out(1'b1, 8'h05, 1'b0, 32'h0, 1'b0);
    drive(1'b1, 8'h0D, 1'b0, 1'b1, 32'h2222);
    @(negedge clk);
    expect_out(1'b1, 8'h08, 1'b1, 32'h2222, 1'b0); // R3
    drive(1'b0, 8'h00, 1'b0, 1'b1, 32'h0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    expect_out(1'b0, 8'h00, 1'b0, 32'h0, 1'b0); // R1
    drive(1'b1, 8'h0E, 1'b0, 1'b1, 32'h3333);
    @(negedge clk);
    expect_out(1'b1, 8'h0E, 1'b1, 32'h3333, 1'b0); // R1 own vector
    drive(1'b0, 8'h00, 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    expect_out(1'b0, 8'h00, 1'b0, 32'h0, 1'b0); // R9

    done = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

endmodule